// File: doc/BRIEF.md
# Byte-Wide Boot Loader DMA Engine

After reset this block takes the processor's external bus and copies a boot image from a narrow, byte-wide nonvolatile memory into internal memory. It reads one byte per external access and packs each run of six bytes into one 48-bit instruction word. Each finished word goes out through a simple synchronous write port. The number of bytes it reads, and the number of words it writes, are fixed by parameters.

Every external access drives a 32-bit byte address, pulls the boot-memory select low and holds the read strobe low for a set number of wait states. The byte is taken from the upper lane of the data bus, which holds bits 23:16. While the copy runs, the program counter stays parked at an idle address. Once the last byte has been read, the engine stops issuing accesses. It then raises a one-cycle completion interrupt, releases the boot select, enables the normal bank selects and loads the wake-up vector into the program counter.

Top module: `boot_byte_loader`

## Requirements
- R1: A start request begins a transfer only when `strap_eboot`=1, `strap_lboot`=0 and `boot_done`=0. For any other strap setting, `boot_sel_oe`=0, `bank_sel_en`=1 and no read strobe is issued.
- R2: After reset, outputs are `rd_n`=1, `boot_sel_n`=1, `ext_addr`=0x0040_0000, `imem_we`=0, `boot_irq`=0, `boot_done`=0 and `pc_out`=0x0002_0004. In byte-boot strap mode, `boot_sel_oe`=1 and `bank_sel_en`=0.
- R3: Each access holds `rd_n` low for WAIT_STATES+1 cycles (7 by default) with `boot_sel_n` low throughout. Data is sampled at the clock edge that ends the last low cycle. Consecutive accesses are separated by exactly one cycle with `rd_n` high.
- R4: The first access reads address 0x0040_0000. The external address rises by one after every byte access.
- R5: The bytes of each group of six are placed first byte to bits 47:40, down to the sixth byte in bits 7:0. `imem_we` pulses for one cycle, in the cycle after the sixth byte is sampled.
- R6: Internal writes go to 0x0002_0000 first, and the address rises by one per word.
- R7: A transfer reads exactly 0x600 bytes and writes exactly 0x100 words. The internal and external counts reach zero on the same clock edge.
- R8: After the final strobe rises, there is one cycle with the select still low. The next cycle has `boot_irq`=1, `boot_sel_n`=1 and `bank_sel_en`=1. The cycle after that has `boot_irq`=0, `boot_done`=1 and `pc_out`=0x0002_0040.
- R9: `pc_out` stays at 0x0002_0004 until `boot_done` is set.
- R10: `boot_done` stays set until reset. A start request while it is set causes no access and leaves `pc_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_eboot | input | 1 | Boot strap, high for external boot |
| strap_lboot | input | 1 | Boot strap, low for byte-memory boot |
| start_req | input | 1 | Request to begin the boot copy |
| boot_data_lane | input | 8 | External data bus bits 23:16 |
| ext_addr | output | 32 | External byte address |
| boot_sel_n | output | 1 | Active-low boot-memory select |
| boot_sel_oe | output | 1 | High when the boot select pin acts as an output |
| rd_n | output | 1 | Active-low read strobe |
| bank_sel_en | output | 1 | Normal bank selects enabled |
| imem_we | output | 1 | Internal memory write enable |
| imem_addr | output | 32 | Internal word address |
| imem_wdata | output | 48 | Packed instruction word |
| boot_irq | output | 1 | One-cycle completion interrupt |
| boot_done | output | 1 | Sticky completion flag |
| pc_out | output | 32 | Program counter value |

## Verification
Most wrong internal states reach the ports within one access of about eight cycles:
- A slipped byte index puts a rotated word on `imem_wdata` at the very next write.
- A wait counter that loads badly changes the width of the strobe.
- An address step that goes wrong shows on `ext_addr` at the next falling edge of the strobe.

Counter faults behave differently. A count that is off only shows at the end of the 1536-byte run, as a missing or extra access or word, or a completion sequence that starts early or late. The wake-up ordering is therefore checked cycle by cycle in the three cycles after the last strobe.

// File: rtl/bl_boot_pkg.sv
package bl_boot_pkg;

   typedef enum logic [2:0] {
      LD_IDLE   = 3'd0,
      LD_STROBE = 3'd1,
      LD_GAP    = 3'd2,
      LD_STOP   = 3'd3,
      LD_WAKE   = 3'd4,
      LD_DONE   = 3'd5
   } ld_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/bl_wait_timer.sv
module bl_wait_timer #(
   parameter int unsigned WAIT_STATES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic last_wait
);
   localparam int unsigned CW = bl_boot_pkg::cnt_width(WAIT_STATES);

   logic [CW-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         wait_cnt <= '0;
      else if (load)
         wait_cnt <= CW'(WAIT_STATES);
      else if (wait_cnt != '0)
         wait_cnt <= wait_cnt - CW'(1);
   end

   assign last_wait = (wait_cnt == '0);

   generate
      if (WAIT_STATES > 0) begin : g_stretch_chk
         p_load_stretches_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            load |=> !last_wait);
      end
   endgenerate

endmodule

// File: rtl/bl_byte_packer.sv
module bl_byte_packer #(
   parameter int unsigned BYTES_PER_WORD = 6,
   parameter int unsigned BYTE_W         = 8,
   localparam int unsigned WORD_W        = BYTES_PER_WORD * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              wrap,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_out
);
   localparam int unsigned IW = bl_boot_pkg::cnt_width(BYTES_PER_WORD - 1);

   logic [IW-1:0] lane_idx;

   assign wrap = (lane_idx == IW'(BYTES_PER_WORD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_idx   <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= take && wrap;
         if (take)
            lane_idx <= wrap ? '0 : lane_idx + IW'(1);
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < BYTES_PER_WORD; gi++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lane_q <= '0;
            else if (take && lane_idx == IW'(gi))
               lane_q <= byte_in;
         end
         // earliest byte lands in the most significant lane
         assign word_out[(BYTES_PER_WORD-1-gi)*BYTE_W +: BYTE_W] = lane_q;
      end
   endgenerate

   p_word_follows_last_byte_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(take && wrap));
   p_write_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

endmodule

// File: rtl/bl_sequencer.sv
module bl_sequencer
   import bl_boot_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned INT_WORDS      = 256,
   parameter int unsigned BYTES_PER_WORD = 6,
   parameter logic [ADDR_W-1:0] EXT_BASE  = 'h0040_0000,
   parameter logic [ADDR_W-1:0] INT_BASE  = 'h0002_0000,
   parameter logic [ADDR_W-1:0] IDLE_PC   = 'h0002_0004,
   parameter logic [ADDR_W-1:0] VECTOR_PC = 'h0002_0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              last_wait,
   input  logic              wrap,
   output logic              load_wait,
   output logic              take,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] pc,
   output logic              rd_n,
   output logic              bsel_n,
   output logic              irq,
   output logic              done,
   output logic              bank_en
);
   localparam int unsigned EXT_BYTES = INT_WORDS * BYTES_PER_WORD;
   localparam int unsigned ECW       = cnt_width(EXT_BYTES);
   localparam int unsigned ICW       = cnt_width(INT_WORDS);

   ld_state_e         state;
   logic [ECW-1:0]    ext_cnt;
   logic [ICW-1:0]    int_cnt;
   logic [ADDR_W-1:0] int_addr;

   assign take      = (state == LD_STROBE) && last_wait;
   assign load_wait = ((state == LD_IDLE) && go) || (state == LD_GAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= LD_IDLE;
         ext_addr <= EXT_BASE;
         ext_cnt  <= ECW'(EXT_BYTES);
         int_addr <= INT_BASE;
         int_cnt  <= ICW'(INT_WORDS);
         wr_addr  <= INT_BASE;
         pc       <= IDLE_PC;
         rd_n     <= 1'b1;
         bsel_n   <= 1'b1;
         irq      <= 1'b0;
         done     <= 1'b0;
         bank_en  <= 1'b0;
      end else begin
         case (state)
            LD_IDLE: begin
               if (go) begin
                  state  <= LD_STROBE;
                  rd_n   <= 1'b0;
                  bsel_n <= 1'b0;
               end
            end
            LD_STROBE: begin
               if (last_wait) begin
                  rd_n     <= 1'b1;
                  ext_addr <= ext_addr + ADDR_W'(1);
                  ext_cnt  <= ext_cnt - ECW'(1);
                  if (wrap && int_cnt != '0) begin
                     wr_addr  <= int_addr;
                     int_addr <= int_addr + ADDR_W'(1);
                     int_cnt  <= int_cnt - ICW'(1);
                  end
                  state <= (ext_cnt == ECW'(1)) ? LD_STOP : LD_GAP;
               end
            end
            LD_GAP: begin
               rd_n  <= 1'b0;
               state <= LD_STROBE;
            end
            LD_STOP: begin
               irq     <= 1'b1;
               bsel_n  <= 1'b1;
               bank_en <= 1'b1;
               state   <= LD_WAKE;
            end
            LD_WAKE: begin
               irq   <= 1'b0;
               pc    <= VECTOR_PC;
               done  <= 1'b1;
               state <= LD_DONE;
            end
            LD_DONE: state <= LD_DONE;
            default: state <= LD_IDLE;
         endcase
      end
   end

   p_strobe_has_select_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !bsel_n);
   p_addr_steps_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> ext_addr == $past(ext_addr) + ADDR_W'(1));
   p_counts_align_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cnt == '0) == (int_cnt == '0));
   p_irq_released_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (bsel_n && bank_en && rd_n));
   p_irq_then_vector_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (!irq && done && pc == VECTOR_PC));
   p_pc_parked_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> pc == IDLE_PC);
   p_done_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && rd_n && $stable(ext_addr) && $stable(pc)));

endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned BYTE_W         = 8,
   parameter int unsigned BYTES_PER_WORD = 6,
   parameter int unsigned INT_WORDS      = 256,
   parameter int unsigned WAIT_STATES    = 6,
   parameter logic [ADDR_W-1:0] EXT_BASE  = 'h0040_0000,
   parameter logic [ADDR_W-1:0] INT_BASE  = 'h0002_0000,
   parameter logic [ADDR_W-1:0] IDLE_PC   = 'h0002_0004,
   parameter logic [ADDR_W-1:0] VECTOR_PC = 'h0002_0040,
   localparam int unsigned WORD_W         = BYTES_PER_WORD * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_eboot,
   input  logic              strap_lboot,
   input  logic              start_req,
   input  logic [BYTE_W-1:0] boot_data_lane,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              boot_sel_n,
   output logic              boot_sel_oe,
   output logic              rd_n,
   output logic              bank_sel_en,
   output logic              imem_we,
   output logic [ADDR_W-1:0] imem_addr,
   output logic [WORD_W-1:0] imem_wdata,
   output logic              boot_irq,
   output logic              boot_done,
   output logic [ADDR_W-1:0] pc_out
);
   generate
      if (BYTES_PER_WORD < 2)    begin : g_bad_pack  $error("BYTES_PER_WORD must be at least 2"); end
      if (INT_WORDS < 1)         begin : g_bad_words $error("INT_WORDS must be at least 1"); end
      if (WAIT_STATES > 255)     begin : g_bad_wait  $error("WAIT_STATES out of range"); end
      if (ADDR_W < 8)            begin : g_bad_addr  $error("ADDR_W too narrow"); end
   endgenerate

   logic byte_mode, go, load_wait, last_wait, take, wrap, bank_en_q;

   assign byte_mode   = strap_eboot && !strap_lboot;
   assign go          = start_req && byte_mode && !boot_done;
   assign boot_sel_oe = byte_mode;
   assign bank_sel_en = bank_en_q || !byte_mode;

   bl_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load_wait), .last_wait(last_wait)
   );

   bl_byte_packer #(.BYTES_PER_WORD(BYTES_PER_WORD), .BYTE_W(BYTE_W)) u_packer (
      .clk(clk), .rst_n(rst_n), .take(take), .byte_in(boot_data_lane),
      .wrap(wrap), .word_valid(imem_we), .word_out(imem_wdata)
   );

   bl_sequencer #(
      .ADDR_W(ADDR_W), .INT_WORDS(INT_WORDS), .BYTES_PER_WORD(BYTES_PER_WORD),
      .EXT_BASE(EXT_BASE), .INT_BASE(INT_BASE), .IDLE_PC(IDLE_PC), .VECTOR_PC(VECTOR_PC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .last_wait(last_wait), .wrap(wrap),
      .load_wait(load_wait), .take(take), .ext_addr(ext_addr), .wr_addr(imem_addr),
      .pc(pc_out), .rd_n(rd_n), .bsel_n(boot_sel_n), .irq(boot_irq),
      .done(boot_done), .bank_en(bank_en_q)
   );

   p_start_gated_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boot_sel_n) |-> $past(byte_mode && !boot_done));

endmodule

// File: tb/boot_byte_loader_tb.sv
module boot_byte_loader_tb;
   localparam int unsigned W     = 6;
   localparam int unsigned BPW   = 6;
   localparam int unsigned WORDS = 256;
   localparam int unsigned TOTAL = WORDS * BPW;
   localparam logic [31:0] EXT_BASE = 32'h0040_0000;
   localparam logic [31:0] INT_BASE = 32'h0002_0000;
   localparam logic [31:0] IDLE_PC  = 32'h0002_0004;
   localparam logic [31:0] VEC_PC   = 32'h0002_0040;

   logic clk = 1'b0, rst_n = 1'b0;
   logic strap_eboot = 1'b1, strap_lboot = 1'b0, start_req = 1'b0;
   logic [7:0]  boot_data_lane;
   logic [31:0] ext_addr, imem_addr, pc_out;
   logic [47:0] imem_wdata;
   logic boot_sel_n, boot_sel_oe, rd_n, bank_sel_en, imem_we, boot_irq, boot_done;

   int checks = 0, errors = 0, cycles = 0;
   int accesses = 0, reads = 0, writes = 0, low_len = 0, high_len = 0, post = 0;
   logic prev_rd = 1'b1;
   logic [7:0] key = 8'h00;

   always #2 clk = ~clk;

   boot_byte_loader u_dut (
      .clk(clk), .rst_n(rst_n), .strap_eboot(strap_eboot), .strap_lboot(strap_lboot),
      .start_req(start_req), .boot_data_lane(boot_data_lane), .ext_addr(ext_addr),
      .boot_sel_n(boot_sel_n), .boot_sel_oe(boot_sel_oe), .rd_n(rd_n),
      .bank_sel_en(bank_sel_en), .imem_we(imem_we), .imem_addr(imem_addr),
      .imem_wdata(imem_wdata), .boot_irq(boot_irq), .boot_done(boot_done), .pc_out(pc_out)
   );

   function automatic logic [7:0] mem_byte(input logic [31:0] a, input logic [7:0] k);
      return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ k ^ {a[10:8], 5'b0};
   endfunction

   function automatic logic [47:0] exp_word(input int idx, input logic [7:0] k);
      logic [47:0] w = '0;
      for (int j = 0; j < BPW; j++)
         w = {w[39:0], mem_byte(EXT_BASE + 32'(idx * BPW + j), k)};
      return w;
   endfunction

   assign boot_data_lane = mem_byte(ext_addr, key);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus and write-port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (!rd_n && prev_rd) begin
            accesses++;
            low_len = 1;
            chk(ext_addr == EXT_BASE + 32'(reads), "R4 access address", ext_addr, EXT_BASE + 32'(reads));
            chk(!boot_sel_n, "R3 select low during strobe", boot_sel_n, 0);
            chk(pc_out == IDLE_PC, "R9 pc parked", pc_out, IDLE_PC);
            if (reads > 0) chk(high_len == 1, "R3 one-cycle gap", high_len, 1);
         end else if (!rd_n) begin
            low_len++;
         end else if (!prev_rd) begin
            chk(low_len == W + 1, "R3 strobe width", low_len, W + 1);
            reads++;
            high_len = 1;
            if (reads == TOTAL) begin
               chk(!boot_sel_n && !boot_irq, "R8 stop cycle keeps select", {boot_sel_n, boot_irq}, 0);
               post = 2;
            end
         end else begin
            high_len++;
            if (post == 2) begin
               chk(boot_irq && boot_sel_n && bank_sel_en && !boot_done, "R8 irq cycle",
                   {boot_irq, boot_sel_n, bank_sel_en, boot_done}, 4'b1110);
               post = 3;
            end else if (post == 3) begin
               chk(!boot_irq && boot_done && pc_out == VEC_PC, "R8 vector cycle",
                   {boot_irq, boot_done, pc_out}, {2'b01, VEC_PC});
               post = 4;
            end
         end
         if (imem_we) begin
            chk(imem_addr == INT_BASE + 32'(writes), "R6 write address", imem_addr, INT_BASE + 32'(writes));
            chk(imem_wdata == exp_word(writes, key), "R5 packed word", imem_wdata, exp_word(writes, key));
            writes++;
         end
         prev_rd = rd_n;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   initial begin
      key = 8'($urandom(32'd20240));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      chk(rd_n && boot_sel_n, "R2 strobe and select idle", {rd_n, boot_sel_n}, 2'b11);
      chk(ext_addr == EXT_BASE, "R2 external start", ext_addr, EXT_BASE);
      chk(!imem_we && !boot_irq && !boot_done, "R2 flags clear", {imem_we, boot_irq, boot_done}, 0);
      chk(pc_out == IDLE_PC, "R2 idle pc", pc_out, IDLE_PC);
      chk(boot_sel_oe && !bank_sel_en, "R2 byte mode pins", {boot_sel_oe, bank_sel_en}, 2'b10);

      // R1: wrong strap settings ignore start
      strap_eboot = 1'b0; strap_lboot = 1'b0;
      @(negedge clk);
      chk(!boot_sel_oe && bank_sel_en, "R1 no-boot pins", {boot_sel_oe, bank_sel_en}, 2'b01);
      pulse_start();
      repeat (30) @(negedge clk);
      chk(accesses == 0, "R1 no access eboot low", accesses, 0);
      strap_eboot = 1'b1; strap_lboot = 1'b1;
      pulse_start();
      repeat (30) @(negedge clk);
      chk(accesses == 0 && !boot_sel_oe, "R1 no access link strap", {accesses, boot_sel_oe}, 0);

      // main transfer
      strap_lboot = 1'b0;
      pulse_start();
      while (!boot_done) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(reads == TOTAL, "R7 byte total", reads, TOTAL);
      chk(writes == WORDS, "R7 word total", writes, WORDS);
      chk(post == 4, "R8 completion seen", post, 4);

      // R10: restart ignored
      pulse_start();
      repeat (40) @(negedge clk);
      chk(accesses == TOTAL, "R10 no further access", accesses, TOTAL);
      chk(boot_done && pc_out == VEC_PC, "R10 done holds", {boot_done, pc_out}, {1'b1, VEC_PC});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule